// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block holds the host-visible programming state of a four-channel DMA controller. A host reaches it through an 8-bit data port with a 4-bit register index and separate write and read strobes. Each channel owns a 16-bit address and a 16-bit count, and each exists as a base copy and a current copy. The host moves these one byte at a time, and a shared byte pointer picks which byte each access touches. Each channel also keeps a mode field, a mask bit, a software request bit and a terminal-count flag. The controller as a whole keeps three command bits and a temporary data byte.

A transfer engine outside this block reads the mode, mask, request, command and current address/count state from the output ports. It writes progress back into the current copies through an update port, and it reports the end of a channel's transfer with a one-cycle terminal-count pulse. On a terminal count, a channel with auto-initialise set copies its base values back into its current copies. Any other channel masks itself.

The byte pointer is a two-state machine. The state `PTR_LO` selects the low byte and `PTR_HI` selects the high byte. The transition *step* goes from `PTR_LO` to `PTR_HI` and from `PTR_HI` to `PTR_LO`, and it fires on every read or write of an address or count register. The transition *clear* returns the machine to `PTR_LO` from either state on a write to index 12. Reset also enters `PTR_LO`.

Top module: `dmac_reg_block`

## Requirements
- R1: After reset the command bits, temporary byte, all modes, request bits, terminal-count flags and address/count copies are zero, every mask bit is 1, and the byte pointer selects the low byte.
- R2: A write to index 2n (address) or 2n+1 (count) of channel n stores the data byte into both the base and the current copy. The byte is the low byte [7:0] when the pointer is low and the high byte [15:8] when the pointer is high, and each such write toggles the pointer.
- R3: A read of index 2n or 2n+1 returns the pointer-selected byte of the channel's current copy in the same cycle and toggles the pointer.
- R4: A write to index 12 sets the byte pointer to the low byte, whatever its state.
- R5: A write to index 11 stores data bits [7:2] into the mode of the channel given by data bits [1:0]. On the ch_mode port, channel n occupies bits [6n+5:6n] as {mode[7:6], decrement[5], auto-init[4], type[3:2]}.
- R6: A write to index 8 keeps data bit 0 as memory-to-memory enable, bit 1 as channel-0 address hold and bit 2 as controller disable. All other bits are dropped.
- R7: A write to index 9 sets the request bit, and a write to index 10 sets the mask bit, of the channel given by data bits [1:0] to the value of data bit 2.
- R8: A write to index 14 clears all four mask bits. A write to index 15 loads mask bit n from data bit n for n = 0..3.
- R9: A read of index 8 returns the request bits in [7:4] and the terminal-count flags in [3:0], then clears the flags. A terminal-count pulse in the same cycle leaves its flag set.
- R10: A terminal-count pulse on channel n sets its flag. If auto-init is set, it reloads the current address and count from the base copies. If auto-init is clear, it sets the mask bit. In the same cycle, a host write takes priority over the reload for the register it writes.
- R11: An engine update writes the given address and count into the current copies of the selected channel only, leaving the base copies unchanged. A host write or a reload of the same register in that cycle takes priority over it.
- R12: Index 13 is a read/write temporary byte.
- R13: Reads of indices 9, 10, 11, 12, 14 and 15 return 0xFF and change no state, including the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx | input | 4 | Register index |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe; ignored while host_wr is high |
| host_rdata | output | 8 | Read data, valid in the cycle host_rd is high |
| tc_pulse | input | 4 | Terminal-count pulse, one bit per channel |
| eng_upd | input | 1 | Engine writes current address/count |
| eng_ch | input | 2 | Channel for the engine update |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| ch_mode | output | 24 | Per-channel mode fields, 6 bits each |
| ch_mask | output | 4 | Per-channel mask bits |
| ch_req | output | 4 | Per-channel software request bits |
| cmd_memcopy | output | 1 | Memory-to-memory enable |
| cmd_hold0 | output | 1 | Channel-0 address hold |
| cmd_disable | output | 1 | Controller disable |
| cur_addr | output | 64 | Current addresses, channel n at [16n+15:16n] |
| cur_count | output | 64 | Current counts, channel n at [16n+15:16n] |

## Verification
On every cycle, the assertions check the following: the byte pointer flips on each word access and falls to the low byte on a clear, and a terminal-count pulse sets its flag and either reloads or masks. They also check that engine updates reach the current copies, that a status read clears the flags, and that write-only locations read 0xFF. Some behaviours only the bench scenarios can show, because they need a history: a split byte write lands in the right halves of both copies, a reload restores values that an engine update had overwritten, and a read of a write-only location leaves the pointer where it was. The bench model tracks every output and every read byte on each clock.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int CH_N   = 4;
    localparam int CH_W   = $clog2(CH_N);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MODE_W = 6;
    localparam int CMD_W  = 3;
    localparam int IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        IDX_A0   = 4'd0,
        IDX_C0   = 4'd1,
        IDX_A1   = 4'd2,
        IDX_C1   = 4'd3,
        IDX_A2   = 4'd4,
        IDX_C2   = 4'd5,
        IDX_A3   = 4'd6,
        IDX_C3   = 4'd7,
        IDX_CMD  = 4'd8,
        IDX_REQ  = 4'd9,
        IDX_MSK1 = 4'd10,
        IDX_MODE = 4'd11,
        IDX_PCLR = 4'd12,
        IDX_TMP  = 4'd13,
        IDX_MCLR = 4'd14,
        IDX_MALL = 4'd15
    } reg_idx_e;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_e;

    typedef struct packed {
        logic [1:0] xfer_mode;
        logic       dec;
        logic       autoinit;
        logic [1:0] xfer_type;
    } chan_mode_t;
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clr,
    output logic hi_sel
);
    ptr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_LO: begin
                if (clr)       state_d = PTR_LO;
                else if (step) state_d = PTR_HI;
            end
            PTR_HI: begin
                if (clr)       state_d = PTR_LO;
                else if (step) state_d = PTR_LO;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        hi_sel = (state_q == PTR_HI);
    end

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (hi_sel != $past(hi_sel)));

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_sel);
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              tmp_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CMD_W-1:0]  cmd,
    output logic [BYTE_W-1:0] tmp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
            tmp <= '0;
        end else begin
            if (cmd_we) cmd <= wdata[CMD_W-1:0];
            if (tmp_we) tmp <= wdata;
        end
    end

    assert_cmd_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (cmd == $past(wdata[CMD_W-1:0])));

    assert_tmp_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_we |=> (tmp == $past(wdata)));
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  chan_mode_t        mode_in,
    input  logic              mask_we,
    input  logic              mask_in,
    input  logic              req_we,
    input  logic              req_in,
    input  logic              eng_we,
    input  logic [WORD_W-1:0] eng_addr,
    input  logic [WORD_W-1:0] eng_cnt,
    input  logic              tc_in,
    input  logic              tc_clr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt,
    output chan_mode_t        mode,
    output logic              mask,
    output logic              req,
    output logic              tc_flag
);
    logic [WORD_W-1:0] base_addr, base_cnt;
    logic              reload;

    function automatic logic [WORD_W-1:0] put_byte(
        input logic [WORD_W-1:0] word,
        input logic              hi,
        input logic [BYTE_W-1:0] b
    );
        logic [WORD_W-1:0] r;
        r = word;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction

    always_comb begin
        reload = tc_in && mode.autoinit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
            mask      <= 1'b1;
            req       <= 1'b0;
            tc_flag   <= 1'b0;
        end else begin
            if (addr_we) begin
                base_addr <= put_byte(base_addr, hi_sel, wdata);
                cur_addr  <= put_byte(cur_addr, hi_sel, wdata);
            end else if (reload) begin
                cur_addr <= base_addr;
            end else if (eng_we) begin
                cur_addr <= eng_addr;
            end

            if (cnt_we) begin
                base_cnt <= put_byte(base_cnt, hi_sel, wdata);
                cur_cnt  <= put_byte(cur_cnt, hi_sel, wdata);
            end else if (reload) begin
                cur_cnt <= base_cnt;
            end else if (eng_we) begin
                cur_cnt <= eng_cnt;
            end

            if (mode_we) mode <= mode_in;

            if (tc_in && !mode.autoinit) mask <= 1'b1;
            else if (mask_we)            mask <= mask_in;

            if (req_we) req <= req_in;

            if (tc_in)       tc_flag <= 1'b1;
            else if (tc_clr) tc_flag <= 1'b0;
        end
    end

    assert_tc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_in |=> tc_flag);

    assert_tc_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in && !mode.autoinit) |=> mask);

    assert_tc_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in && mode.autoinit && !addr_we) |=> (cur_addr == $past(base_addr)));

    assert_eng_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !tc_in && !cnt_we) |=> (cur_cnt == $past(eng_cnt)));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && !tc_in) |=> !tc_flag);
endmodule

// File: rtl/dmac_reg_block.sv
module dmac_reg_block
    import dmac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         host_idx,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic                     host_wr,
    input  logic                     host_rd,
    output logic [BYTE_W-1:0]        host_rdata,
    input  logic [CH_N-1:0]          tc_pulse,
    input  logic                     eng_upd,
    input  logic [CH_W-1:0]          eng_ch,
    input  logic [WORD_W-1:0]        eng_addr,
    input  logic [WORD_W-1:0]        eng_cnt,
    output logic [CH_N*MODE_W-1:0]   ch_mode,
    output logic [CH_N-1:0]          ch_mask,
    output logic [CH_N-1:0]          ch_req,
    output logic                     cmd_memcopy,
    output logic                     cmd_hold0,
    output logic                     cmd_disable,
    output logic [CH_N*WORD_W-1:0]   cur_addr,
    output logic [CH_N*WORD_W-1:0]   cur_count
);
    reg_idx_e           idx;
    logic               rd_act;
    logic               word_sel;
    logic [CH_W-1:0]    word_ch;
    logic               is_cnt;
    logic               hi_sel;
    logic               wo_idx;
    logic [CH_W-1:0]    data_ch;
    logic [CMD_W-1:0]   cmd;
    logic [BYTE_W-1:0]  tmp;
    logic [CH_N-1:0]    tc_vec;
    logic [WORD_W-1:0]  a_arr [CH_N];
    logic [WORD_W-1:0]  c_arr [CH_N];
    logic [WORD_W-1:0]  sel_word;

    always_comb begin
        idx      = reg_idx_e'(host_idx);
        rd_act   = host_rd && !host_wr;
        word_sel = !host_idx[IDX_W-1];
        word_ch  = host_idx[CH_W:1];
        is_cnt   = host_idx[0];
        data_ch  = host_wdata[CH_W-1:0];
        wo_idx   = (idx == IDX_REQ) || (idx == IDX_MSK1) || (idx == IDX_MODE) ||
                   (idx == IDX_PCLR) || (idx == IDX_MCLR) || (idx == IDX_MALL);
    end

    dmac_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   ((host_wr || rd_act) && word_sel),
        .clr    (host_wr && (idx == IDX_PCLR)),
        .hi_sel (hi_sel)
    );

    dmac_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_we (host_wr && (idx == IDX_CMD)),
        .tmp_we (host_wr && (idx == IDX_TMP)),
        .wdata  (host_wdata),
        .cmd    (cmd),
        .tmp    (tmp)
    );

    assign cmd_memcopy = cmd[0];
    assign cmd_hold0   = cmd[1];
    assign cmd_disable = cmd[2];

    for (genvar g = 0; g < CH_N; g++) begin : g_chan
        logic       addr_we, cnt_we, mode_we, mask_we, mask_in, req_we;
        chan_mode_t mode_g;

        always_comb begin
            addr_we = host_wr && word_sel && (word_ch == CH_W'(g)) && !is_cnt;
            cnt_we  = host_wr && word_sel && (word_ch == CH_W'(g)) && is_cnt;
            mode_we = host_wr && (idx == IDX_MODE) && (data_ch == CH_W'(g));
            req_we  = host_wr && (idx == IDX_REQ) && (data_ch == CH_W'(g));
            mask_we = 1'b0;
            mask_in = 1'b0;
            if (host_wr) begin
                unique case (idx)
                    IDX_MSK1: begin
                        mask_we = (data_ch == CH_W'(g));
                        mask_in = host_wdata[CH_W];
                    end
                    IDX_MCLR: begin
                        mask_we = 1'b1;
                        mask_in = 1'b0;
                    end
                    IDX_MALL: begin
                        mask_we = 1'b1;
                        mask_in = host_wdata[g];
                    end
                    default: ;
                endcase
            end
        end

        dmac_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (addr_we),
            .cnt_we   (cnt_we),
            .hi_sel   (hi_sel),
            .wdata    (host_wdata),
            .mode_we  (mode_we),
            .mode_in  (chan_mode_t'(host_wdata[BYTE_W-1:BYTE_W-MODE_W])),
            .mask_we  (mask_we),
            .mask_in  (mask_in),
            .req_we   (req_we),
            .req_in   (host_wdata[CH_W]),
            .eng_we   (eng_upd && (eng_ch == CH_W'(g))),
            .eng_addr (eng_addr),
            .eng_cnt  (eng_cnt),
            .tc_in    (tc_pulse[g]),
            .tc_clr   (rd_act && (idx == IDX_CMD)),
            .cur_addr (a_arr[g]),
            .cur_cnt  (c_arr[g]),
            .mode     (mode_g),
            .mask     (ch_mask[g]),
            .req      (ch_req[g]),
            .tc_flag  (tc_vec[g])
        );

        assign ch_mode[g*MODE_W +: MODE_W]    = mode_g;
        assign cur_addr[g*WORD_W +: WORD_W]   = a_arr[g];
        assign cur_count[g*WORD_W +: WORD_W]  = c_arr[g];
    end

    always_comb begin
        sel_word   = is_cnt ? c_arr[word_ch] : a_arr[word_ch];
        host_rdata = '1;
        if (word_sel) begin
            host_rdata = hi_sel ? sel_word[WORD_W-1:BYTE_W] : sel_word[BYTE_W-1:0];
        end else if (idx == IDX_CMD) begin
            host_rdata = {ch_req, tc_vec};
        end else if (idx == IDX_TMP) begin
            host_rdata = tmp;
        end
    end

    assert_wo_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && wo_idx) |-> (host_rdata == '1));

    assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && (idx == IDX_CMD) && (tc_pulse == '0)) |=> (tc_vec == '0));
endmodule

// File: tb/dmac_reg_block_test.sv
module dmac_reg_block_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  d_idx = '0;
    logic [7:0]  d_wd = '0;
    logic        d_wr = 1'b0, d_rd = 1'b0;
    logic [7:0]  rdata;
    logic [3:0]  d_tc = '0;
    logic        d_eu = 1'b0;
    logic [1:0]  d_ech = '0;
    logic [15:0] d_ea = '0, d_ec = '0;
    logic [23:0] ch_mode;
    logic [3:0]  ch_mask, ch_req;
    logic        cmd_memcopy, cmd_hold0, cmd_disable;
    logic [63:0] cur_addr, cur_count;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_mode[4], m_mask[4], m_req[4], m_tc[4];
    int m_cmd, m_tmp, m_hi;

    always #10 clk = ~clk;

    dmac_reg_block uut (
        .clk(clk), .rst_n(rst_n), .host_idx(d_idx), .host_wdata(d_wd),
        .host_wr(d_wr), .host_rd(d_rd), .host_rdata(rdata), .tc_pulse(d_tc),
        .eng_upd(d_eu), .eng_ch(d_ech), .eng_addr(d_ea), .eng_cnt(d_ec),
        .ch_mode(ch_mode), .ch_mask(ch_mask), .ch_req(ch_req),
        .cmd_memcopy(cmd_memcopy), .cmd_hold0(cmd_hold0), .cmd_disable(cmd_disable),
        .cur_addr(cur_addr), .cur_count(cur_count)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
            m_mode[i] = 0; m_mask[i] = 1; m_req[i] = 0; m_tc[i] = 0;
        end
        m_cmd = 0; m_tmp = 0; m_hi = 0;
    endtask

    function automatic int exp_read(input int ix);
        int w;
        int s;
        if (ix < 8) begin
            w = (ix % 2 == 1) ? m_cc[ix/2] : m_ca[ix/2];
            return (m_hi != 0) ? ((w >> 8) & 255) : (w & 255);
        end
        if (ix == 8) begin
            s = 0;
            for (int i = 0; i < 4; i++) s = s | (m_req[i] << (4 + i)) | (m_tc[i] << i);
            return s;
        end
        if (ix == 13) return m_tmp;
        return 255;
    endfunction

    task automatic model_step();
        int om[4], oba[4], obc[4];
        bit wa[4], wc[4];
        int ix, v, ch, sh, keep;
        for (int i = 0; i < 4; i++) begin
            om[i] = m_mode[i]; oba[i] = m_ba[i]; obc[i] = m_bc[i]; wa[i] = 0; wc[i] = 0;
        end
        ix = int'(d_idx); v = int'(d_wd);
        if (d_wr) begin
            if (ix < 8) begin
                ch = ix / 2;
                sh = (m_hi != 0) ? 8 : 0;
                keep = (m_hi != 0) ? 'h00FF : 'hFF00;
                if (ix % 2 == 0) begin
                    m_ba[ch] = (m_ba[ch] & keep) | (v << sh);
                    m_ca[ch] = (m_ca[ch] & keep) | (v << sh);
                    wa[ch] = 1;
                end else begin
                    m_bc[ch] = (m_bc[ch] & keep) | (v << sh);
                    m_cc[ch] = (m_cc[ch] & keep) | (v << sh);
                    wc[ch] = 1;
                end
                m_hi = 1 - m_hi;
            end else begin
                case (ix)
                    8:  m_cmd = v & 7;
                    9:  m_req[v & 3] = (v >> 2) & 1;
                    10: m_mask[v & 3] = (v >> 2) & 1;
                    11: m_mode[v & 3] = v >> 2;
                    12: m_hi = 0;
                    13: m_tmp = v;
                    14: for (int i = 0; i < 4; i++) m_mask[i] = 0;
                    default: for (int i = 0; i < 4; i++) m_mask[i] = (v >> i) & 1;
                endcase
            end
        end else if (d_rd) begin
            if (ix < 8) m_hi = 1 - m_hi;
            else if (ix == 8) for (int i = 0; i < 4; i++) m_tc[i] = 0;
        end
        if (d_eu) begin
            ch = int'(d_ech);
            if (!wa[ch]) m_ca[ch] = int'(d_ea);
            if (!wc[ch]) m_cc[ch] = int'(d_ec);
        end
        for (int i = 0; i < 4; i++) begin
            if (d_tc[i]) begin
                m_tc[i] = 1;
                if (((om[i] >> 2) & 1) != 0) begin
                    if (!wa[i]) m_ca[i] = oba[i];
                    if (!wc[i]) m_cc[i] = obc[i];
                end else begin
                    m_mask[i] = 1;
                end
            end
        end
    endtask

    task automatic compare_outputs(input string tag);
        logic [23:0] em;
        logic [63:0] ea, ec;
        logic [3:0]  emk, erq;
        for (int i = 0; i < 4; i++) begin
            em[i*6 +: 6]  = 6'(m_mode[i]);
            ea[i*16 +: 16] = 16'(m_ca[i]);
            ec[i*16 +: 16] = 16'(m_cc[i]);
            emk[i] = m_mask[i][0];
            erq[i] = m_req[i][0];
        end
        check(tag, "ch_mode", 64'(ch_mode), 64'(em));
        check(tag, "ch_mask", 64'(ch_mask), 64'(emk));
        check(tag, "ch_req", 64'(ch_req), 64'(erq));
        check(tag, "command", 64'({cmd_disable, cmd_hold0, cmd_memcopy}), 64'(m_cmd));
        check(tag, "cur_addr", cur_addr, ea);
        check(tag, "cur_count", cur_count, ec);
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        #5;
        if (d_rd && !d_wr) check(tag, "rdata", 64'(rdata), 64'(exp_read(int'(d_idx))));
        model_step();
        @(posedge clk);
        #2;
        compare_outputs(tag);
        d_wr = 0; d_rd = 0; d_tc = '0; d_eu = 0;
    endtask

    task automatic wr_reg(input int ix, input int v, input string tag);
        d_idx = 4'(ix); d_wd = 8'(v); d_wr = 1; tick(tag);
    endtask

    task automatic rd_reg(input int ix, input string tag);
        d_idx = 4'(ix); d_rd = 1; tick(tag);
    endtask

    task automatic pulse_tc(input int bits, input string tag);
        d_tc = 4'(bits); tick(tag);
    endtask

    task automatic eng(input int ch, input int a, input int c, input string tag);
        d_eu = 1; d_ech = 2'(ch); d_ea = 16'(a); d_ec = 16'(c); tick(tag);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                done = 1;
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on every output and on reads
        @(posedge clk); #2;
        compare_outputs("R1");
        rd_reg(0, "R1");
        rd_reg(8, "R1");
        rd_reg(13, "R1");
        wr_reg(12, 0, "R4");

        // R2, R3: byte-wise programming and read-back for every channel
        for (int ch = 0; ch < 4; ch++) begin
            wr_reg(2*ch, 16'h10 + ch, "R2");
            wr_reg(2*ch, 16'hA0 + ch, "R2");
            wr_reg(2*ch+1, 16'h30 + ch, "R2");
            wr_reg(2*ch+1, 16'h0C + ch, "R2");
        end
        for (int ch = 0; ch < 4; ch++) begin
            rd_reg(2*ch, "R3");
            rd_reg(2*ch, "R3");
            rd_reg(2*ch+1, "R3");
            rd_reg(2*ch+1, "R3");
        end

        // R4: clear after a single byte, next write hits the low byte
        wr_reg(2, 8'h55, "R4");
        wr_reg(12, 0, "R4");
        wr_reg(2, 8'h66, "R4");
        wr_reg(12, 0, "R4");
        wr_reg(12, 0, "R4");
        rd_reg(2, "R4");

        // R5: mode fields per channel
        wr_reg(11, 8'b01_0_1_01_00, "R5");
        wr_reg(11, 8'b10_1_0_10_01, "R5");
        wr_reg(11, 8'b11_1_1_11_10, "R5");
        wr_reg(11, 8'b00_0_0_00_11, "R5");

        // R6: command bits
        wr_reg(8, 8'hFF, "R6");
        wr_reg(8, 8'hFA, "R6");

        // R7: request and single mask
        wr_reg(9, 8'h06, "R7");
        wr_reg(9, 8'h07, "R7");
        wr_reg(9, 8'h02, "R7");
        wr_reg(10, 8'h01, "R7");
        wr_reg(10, 8'h07, "R7");

        // R8: clear all masks, then write pattern
        wr_reg(14, 8'h00, "R8");
        wr_reg(15, 8'hF5, "R8");
        wr_reg(15, 8'h0A, "R8");
        wr_reg(14, 8'h00, "R8");

        // R11: engine updates current copies only
        eng(0, 16'h1234, 16'h0042, "R11");
        eng(2, 16'hBEEF, 16'h0007, "R11");
        wr_reg(12, 0, "R11");
        rd_reg(0, "R11");
        rd_reg(0, "R11");

        // R10: channel 0 (auto-init) reloads, channel 1 (no auto-init) masks
        pulse_tc(4'b0001, "R10");
        pulse_tc(4'b0010, "R10");
        pulse_tc(4'b0100, "R10");
        eng(3, 16'h7777, 16'h8888, "R10");
        d_idx = 4'd6; d_wd = 8'h99; d_wr = 1; d_tc = 4'b1000; tick("R10");
        wr_reg(12, 0, "R10");

        // R9: status read returns flags, then clears; same-cycle pulse survives
        rd_reg(8, "R9");
        rd_reg(8, "R9");
        pulse_tc(4'b1000, "R9");
        d_idx = 4'd8; d_rd = 1; d_tc = 4'b0010; tick("R9");
        rd_reg(8, "R9");
        rd_reg(8, "R9");

        // R12: temporary byte
        wr_reg(13, 8'hC3, "R12");
        rd_reg(13, "R12");
        wr_reg(13, 8'h3C, "R12");
        rd_reg(13, "R12");

        // R13: write-only reads return all ones and leave the pointer alone
        wr_reg(12, 0, "R13");
        rd_reg(4, "R13");
        rd_reg(9, "R13");
        rd_reg(10, "R13");
        rd_reg(11, "R13");
        rd_reg(12, "R13");
        rd_reg(14, "R13");
        rd_reg(15, "R13");
        rd_reg(4, "R13");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule